// File: doc/BRIEF.md
# Ascent-Descent Address Fault Locator

This block is a built-in self-test sequencer for a word-addressed memory of configurable depth. It looks for address-decoding faults, meaning a write to one location that also changes another. It owns the memory port for the whole run. It drives write enable, read request, address and write data, and it takes back the read data.

A run starts with a pulse on `start`. The block then makes an upward pass and a downward pass. Each pass first zeroes every location. It then visits each address in turn: it reads the address, expects zero, and writes all ones. The first location that reads nonzero becomes the victim.

After a victim is found, the block zeroes the memory again and walks in the same direction a second time. This time it reads the victim after every write. If the victim reads nonzero, the write made just before that read names the aggressor. If the walk ends and the victim never changes, the fault is reported as intermittent. Once the run ends, the outcome is held on `done`, `fail`, `err_code`, `victim_addr` and `aggressor_addr` until the next start.

Top module: `amf_locator`

## Requirements
- R1: While `rst_n` is low and after its release, `done`, `fail`, `err_code`, `mem_we` and `mem_re` are all zero.
- R2: Each pass and each isolation walk begins by writing zero to every location, one location per cycle, from address 0 upward.
- R3: A fault-free run visits each address twice. The upward pass goes from 0 to DEPTH-1 and the downward pass from DEPTH-1 to 0. Each visit is one read cycle followed by one cycle that writes all ones. The run ends with `done`=1, `fail`=0 and `err_code`=0 exactly 6*DEPTH cycles after the edge that accepts `start`, and every location then holds all ones.
- R4: In either pass, the first visited address that reads nonzero is latched on `victim_addr`, and isolation starts in that pass's direction.
- R5: Isolation first reads location 0. If it is nonzero, the run ends with `err_code`=1 (clear failure). The same code is reported if the victim is already nonzero before the first isolation write.
- R6: Upward isolation reads the victim after each write. When the victim reads nonzero, the run ends with `err_code`=2 and `aggressor_addr` set to the address written in the preceding step.
- R7: Downward isolation works the same way and ends with `err_code`=3 and `aggressor_addr` set to the address written in the preceding step.
- R8: During isolation, every visited address except the victim gets all ones. The block never writes a nonzero value to the victim during isolation. In an upward aggressor case the victim receives no write of ones from the block in the whole run.
- R9: If an isolation walk covers every address and the victim never reads nonzero, the run ends with `err_code`=4 (upward) or 5 (downward), and `aggressor_addr`=0.
- R10: `mem_we` and `mem_re` are never high in the same cycle. Read data is sampled on the cycle after `mem_re`.
- R11: Once `done` is high, `fail` equals (`err_code`!=0). The outputs hold and the memory port stays idle until a new `start`. A new `start` restarts the run.
- R12: A `start` pulse that arrives while a run is in progress is ignored. The run's length and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run when idle or finished |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, valid the cycle after mem_re |
| done | output | 1 | Run finished, outcome valid |
| fail | output | 1 | Run finished with a fault |
| err_code | output | 3 | Outcome code (0 none, 1..5 as in R5-R9) |
| victim_addr | output | AW | Location found corrupted |
| aggressor_addr | output | AW | Write that corrupted the victim |

## Verification
The memory model is fed several fault patterns, and each one reaches a different part of the block:
- A clean memory shows that the run length and the final all-ones contents are correct.
- An alias from a low address to a higher one is caught in the upward pass. It is tried in the middle of the range and at both adjacent-address edges.
- An alias from a high address to a lower one gets past the upward pass and is caught only by the downward pass. It is tried at the widest span, top to address 0.
- A stuck bit at location 0 shows the clear-failure path.
- An alias that fires only on one particular write makes the isolation walk fail to repeat the fault. This separates the intermittent codes for each direction from the aggressor codes.

// File: rtl/amf_pkg.sv
// Shared types for the address fault locator.
// Assumes: outcome codes are observed by software as plain 3-bit numbers.
package amf_pkg;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_CLEAR      = 3'd1,
        ERR_UP_AGGR    = 3'd2,
        ERR_DOWN_AGGR  = 3'd3,
        ERR_UP_INTER   = 3'd4,
        ERR_DOWN_INTER = 3'd5
    } err_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_PASS_RD,
        ST_PASS_EV,
        ST_ZERO_RD,
        ST_ZERO_EV,
        ST_ISO_RD,
        ST_ISO_EV,
        ST_DONE
    } state_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

endpackage

// File: rtl/amf_step_count.sv
// Step counter shared by every walk of the locator.
// Counts 0..DEPTH so that a walk can make one extra read after its last write.
// Assumes: clr has priority over inc; DEPTH >= 2.
module amf_step_count #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          at_last,
    output logic          at_end
);

    localparam logic [CW-1:0] LAST_STEP = CW'(DEPTH - 1);
    localparam logic [CW-1:0] END_STEP  = CW'(DEPTH);

    // Step register: cleared on reset or on request, else advanced on inc.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Boundary flags used by the controller.
    always_comb begin
        at_last = (cnt == LAST_STEP);
        at_end  = (cnt == END_STEP);
    end

endmodule

// File: rtl/amf_addr_map.sv
// Maps a step count to the address visited and to the address written one
// step earlier, for either walking direction.
// Assumes: cnt < DEPTH when cur_addr is used, 1 <= cnt <= DEPTH for prev_addr.
module amf_addr_map #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int CW    = 7
) (
    input  amf_pkg::dir_e  dir,
    input  logic [CW-1:0]  cnt,
    output logic [AW-1:0]  cur_addr,
    output logic [AW-1:0]  prev_addr
);

    localparam logic [CW-1:0] TOP   = CW'(DEPTH - 1);
    localparam logic [CW-1:0] SPAN  = CW'(DEPTH);

    logic [CW-1:0] cur_w;
    logic [CW-1:0] prev_w;

    // Direction-dependent address arithmetic.
    always_comb begin
        if (dir == amf_pkg::DIR_UP) begin
            cur_w  = cnt;
            prev_w = cnt - 1'b1;
        end else begin
            cur_w  = TOP - cnt;
            prev_w = SPAN - cnt;
        end
        cur_addr  = cur_w[AW-1:0];
        prev_addr = prev_w[AW-1:0];
    end

endmodule

// File: rtl/amf_ctrl.sv
// Sequencer of the locator: zeroing sweeps, the two detection passes, the
// confirm read of location 0 and the isolation walk.
// Assumes: mem_rdata is valid the cycle after mem_re; one access per cycle.
module amf_ctrl
    import amf_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] cnt,
    input  logic          at_last,
    input  logic          at_end,
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] prev_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output dir_e          dir,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          done,
    output logic [2:0]    err_code,
    output logic [AW-1:0] victim_addr,
    output logic [AW-1:0] aggressor_addr,
    output logic          iso_phase
);

    state_e        state_q, state_d;
    dir_e          dir_q;
    logic          iso_q;
    logic          done_q;
    err_e          code_q;
    logic [AW-1:0] victim_q;
    logic [AW-1:0] aggr_q;

    logic          rd_nz;
    logic          start_run;
    logic          hit;
    logic          to_down;
    logic          fin;
    logic          fin_aggr;
    err_e          fin_code;

    assign rd_nz = |mem_rdata;

    // Next state, memory port and event strobes for the current state.
    always_comb begin
        state_d   = state_q;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        start_run = 1'b0;
        hit       = 1'b0;
        to_down   = 1'b0;
        fin       = 1'b0;
        fin_aggr  = 1'b0;
        fin_code  = ERR_NONE;
        case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    start_run = 1'b1;
                    cnt_clr   = 1'b1;
                    state_d   = ST_CLEAR;
                end
            end
            ST_CLEAR: begin
                mem_we   = 1'b1;
                mem_addr = cnt[AW-1:0];
                if (at_last) begin
                    cnt_clr = 1'b1;
                    state_d = iso_q ? ST_ZERO_RD : ST_PASS_RD;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_PASS_RD: begin
                mem_re   = 1'b1;
                mem_addr = cur_addr;
                state_d  = ST_PASS_EV;
            end
            ST_PASS_EV: begin
                if (rd_nz) begin
                    hit     = 1'b1;
                    cnt_clr = 1'b1;
                    state_d = ST_CLEAR;
                end else begin
                    mem_we    = 1'b1;
                    mem_addr  = cur_addr;
                    mem_wdata = '1;
                    if (!at_last) begin
                        cnt_inc = 1'b1;
                        state_d = ST_PASS_RD;
                    end else if (dir_q == DIR_UP) begin
                        cnt_clr = 1'b1;
                        to_down = 1'b1;
                        state_d = ST_CLEAR;
                    end else begin
                        fin     = 1'b1;
                        state_d = ST_DONE;
                    end
                end
            end
            ST_ZERO_RD: begin
                mem_re   = 1'b1;
                mem_addr = '0;
                state_d  = ST_ZERO_EV;
            end
            ST_ZERO_EV: begin
                if (rd_nz) begin
                    fin      = 1'b1;
                    fin_code = ERR_CLEAR;
                    state_d  = ST_DONE;
                end else begin
                    state_d  = ST_ISO_RD;
                end
            end
            ST_ISO_RD: begin
                mem_re   = 1'b1;
                mem_addr = victim_q;
                state_d  = ST_ISO_EV;
            end
            ST_ISO_EV: begin
                if (rd_nz) begin
                    fin     = 1'b1;
                    state_d = ST_DONE;
                    if (cnt == '0) begin
                        fin_code = ERR_CLEAR;
                    end else begin
                        fin_aggr = 1'b1;
                        fin_code = (dir_q == DIR_UP) ? ERR_UP_AGGR : ERR_DOWN_AGGR;
                    end
                end else if (at_end) begin
                    fin      = 1'b1;
                    state_d  = ST_DONE;
                    fin_code = (dir_q == DIR_UP) ? ERR_UP_INTER : ERR_DOWN_INTER;
                end else begin
                    if (cur_addr != victim_q) begin
                        mem_we    = 1'b1;
                        mem_addr  = cur_addr;
                        mem_wdata = '1;
                    end
                    cnt_inc = 1'b1;
                    state_d = ST_ISO_RD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and outcome registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            dir_q    <= DIR_UP;
            iso_q    <= 1'b0;
            done_q   <= 1'b0;
            code_q   <= ERR_NONE;
            victim_q <= '0;
            aggr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_run) begin
                dir_q    <= DIR_UP;
                iso_q    <= 1'b0;
                done_q   <= 1'b0;
                code_q   <= ERR_NONE;
                victim_q <= '0;
                aggr_q   <= '0;
            end
            if (to_down) begin
                dir_q <= DIR_DOWN;
            end
            if (hit) begin
                victim_q <= cur_addr;
                iso_q    <= 1'b1;
            end
            if (fin) begin
                done_q <= 1'b1;
                code_q <= fin_code;
                if (fin_aggr) begin
                    aggr_q <= prev_addr;
                end
            end
        end
    end

    // Register outputs.
    always_comb begin
        dir            = dir_q;
        done           = done_q;
        err_code       = code_q;
        victim_addr    = victim_q;
        aggressor_addr = aggr_q;
        iso_phase      = iso_q & ~done_q;
    end

endmodule

// File: rtl/amf_locator.sv
// Top of the address fault locator: step counter, direction address map and
// sequencer. Owns the memory port for the whole run.
// Assumes: DEPTH >= 2; memory returns read data one cycle after mem_re.
module amf_locator #(
    parameter int DEPTH = 64,
    parameter int DW    = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic          fail,
    output logic [2:0]    err_code,
    output logic [AW-1:0] victim_addr,
    output logic [AW-1:0] aggressor_addr
);

    localparam int CW = AW + 1;

    logic [CW-1:0]  cnt;
    logic           cnt_clr;
    logic           cnt_inc;
    logic           at_last;
    logic           at_end;
    amf_pkg::dir_e  dir;
    logic [AW-1:0]  cur_addr;
    logic [AW-1:0]  prev_addr;
    logic           iso_phase;

    amf_step_count #(.DEPTH(DEPTH), .CW(CW)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .cnt     (cnt),
        .at_last (at_last),
        .at_end  (at_end)
    );

    amf_addr_map #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_map (
        .dir       (dir),
        .cnt       (cnt),
        .cur_addr  (cur_addr),
        .prev_addr (prev_addr)
    );

    amf_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .cnt            (cnt),
        .at_last        (at_last),
        .at_end         (at_end),
        .cur_addr       (cur_addr),
        .prev_addr      (prev_addr),
        .mem_rdata      (mem_rdata),
        .cnt_clr        (cnt_clr),
        .cnt_inc        (cnt_inc),
        .dir            (dir),
        .mem_we         (mem_we),
        .mem_re         (mem_re),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .done           (done),
        .err_code       (err_code),
        .victim_addr    (victim_addr),
        .aggressor_addr (aggressor_addr),
        .iso_phase      (iso_phase)
    );

    // Fault flag derived from the held outcome.
    always_comb begin
        fail = done & (err_code != 3'd0);
    end

endmodule

// File: rtl/amf_locator_chk.sv
// Protocol and outcome checks for amf_locator, attached by bind.
// Assumes: connected to the top's ports and its internal iso_phase.
module amf_locator_chk #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          done,
    input logic [2:0]    err_code,
    input logic [AW-1:0] victim_addr,
    input logic [AW-1:0] aggressor_addr,
    input logic          iso_phase
);

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R10

    AST_VICTIM_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_phase && mem_we && mem_addr == victim_addr) |-> (mem_wdata == '0)); // R8

    AST_OUTCOME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(err_code) && $stable(victim_addr)
                              && $stable(aggressor_addr))); // R11

    AST_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_we && !mem_re)); // R11

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && mem_we && mem_addr == '0 && mem_wdata == '0)); // R2

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code <= 3'd5)); // R9

endmodule

bind amf_locator amf_locator_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .mem_we         (mem_we),
    .mem_re         (mem_re),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .done           (done),
    .err_code       (err_code),
    .victim_addr    (victim_addr),
    .aggressor_addr (aggressor_addr),
    .iso_phase      (iso_phase)
);

// File: tb/tb_amf_locator.sv
// Scoreboard bench: the driver queues expected outcomes, the monitor pops and
// compares them when done rises. The memory model injects faults.
module tb_amf_locator;

    localparam int DEPTH = 64;
    localparam int DW    = 16;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mem_we, mem_re;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          done, fail;
    logic [2:0]    err_code;
    logic [AW-1:0] victim_addr, aggressor_addr;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    amf_locator #(.DEPTH(DEPTH), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .fail(fail), .err_code(err_code),
        .victim_addr(victim_addr), .aggressor_addr(aggressor_addr)
    );

    // Memory model with fault injection: 0 none, 1 alias, 2 stuck bit at 0.
    logic [DW-1:0] mem [DEPTH];
    int  f_kind = 0, f_aggr = 0, f_vict = 0, f_nth = 0;
    int  wr_cnt = 0, vict_ones = 0, overlap = 0;
    logic prefill = 1'b0;

    always @(posedge clk) begin
        if (prefill) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 16'h5A00 ^ 16'(i);
            wr_cnt    <= 0;
            vict_ones <= 0;
        end else begin
            if (mem_we && mem_re) overlap <= overlap + 1;
            if (mem_re)
                mem_rdata <= (f_kind == 2 && mem_addr == '0) ? (mem[0] | 16'h1) : mem[mem_addr];
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                if (mem_wdata != '0 && int'(mem_addr) == f_vict) vict_ones <= vict_ones + 1;
                if (f_kind == 1 && mem_wdata != '0 && int'(mem_addr) == f_aggr) begin
                    wr_cnt <= wr_cnt + 1;
                    if (f_nth == 0 || wr_cnt + 1 == f_nth) mem[f_vict] <= '1;
                end
            end
        end
    end

    typedef struct {
        int    code;
        int    victim;
        int    aggr;
        int    vones;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: on each rising done, pop the expected outcome and compare.
    initial begin
        logic done_prev;
        done_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (done && !done_prev) begin
                if (sb_q.size() == 0) begin
                    chk("R11", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(e.tag, "err_code", int'(err_code), e.code);
                    chk("R11", "fail flag", int'(fail), int'(e.code != 0));
                    chk(e.tag, "victim_addr", int'(victim_addr), e.victim);
                    chk(e.tag, "aggressor_addr", int'(aggressor_addr), e.aggr);
                    if (e.vones >= 0) chk("R8", "victim ones writes", vict_ones, e.vones);
                end
            end
            done_prev = done;
        end
    end

    // Driver: set up the fault, queue the expectation, run, measure length.
    task automatic run_case(input int kind, input int aggr, input int vict, input int nth,
                            input int e_code, input int e_vict, input int e_aggr,
                            input int e_vones, input string tag,
                            input int e_cycles, input bit mid_start);
        exp_t e;
        int   cyc;
        @(negedge clk);
        f_kind = kind; f_aggr = aggr; f_vict = vict; f_nth = nth;
        prefill = 1'b1;
        @(negedge clk);
        prefill = 1'b0;
        e.code = e_code; e.victim = e_vict; e.aggr = e_aggr; e.vones = e_vones; e.tag = tag;
        sb_q.push_back(e);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (mid_start) start = (cyc == 100);
        end
        start = 1'b0;
        if (e_cycles > 0) chk(mid_start ? "R12" : "R3", "run length", cyc, e_cycles);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    // Main sequence.
    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "fail in reset", int'(fail), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "err_code after reset", int'(err_code), 0);
        chk("R1", "port idle after reset", int'(mem_we | mem_re), 0);

        // R3: clean memory, full run length and final contents.
        run_case(0, 0, 99, 0, 0, 0, 0, -1, "R3", 6 * DEPTH, 1'b0);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < DEPTH; i++) if (mem[i] != 16'hFFFF) bad++;
            chk("R3", "locations not all ones", bad, 0);
        end

        // R12: start pulse during a run is ignored.
        run_case(0, 0, 99, 0, 0, 0, 0, -1, "R12", 6 * DEPTH, 1'b1);

        // R4/R6: upward alias in mid range; R2: untouched top word was zeroed.
        run_case(1, 5, 20, 0, 2, 20, 5, 0, "R6", 0, 1'b0);
        chk("R2", "top word after isolation", int'(mem[DEPTH-1]), 0);

        // R11: outcome holds and port idles while finished.
        repeat (5) @(negedge clk);
        chk("R11", "done held", int'(done), 1);
        chk("R11", "code held", int'(err_code), 2);
        chk("R11", "port idle", int'(mem_we | mem_re), 0);

        // R6 boundaries: adjacent at top and at bottom.
        run_case(1, 62, 63, 0, 2, 63, 62, 0, "R6", 0, 1'b0);
        run_case(1, 0, 1, 0, 2, 1, 0, 0, "R6", 0, 1'b0);

        // R5/R7: downward aliases, mid range and widest span.
        run_case(1, 40, 10, 0, 3, 10, 40, 1, "R7", 0, 1'b0);
        run_case(1, 63, 0, 0, 3, 0, 63, -1, "R7", 0, 1'b0);

        // R5: stuck bit at location 0 is a clear failure.
        run_case(2, 0, 0, 0, 1, 0, 0, -1, "R5", 0, 1'b0);

        // R9: one-shot aliases give intermittent codes.
        run_case(1, 3, 30, 1, 4, 30, 0, 0, "R9", 0, 1'b0);
        run_case(1, 50, 7, 2, 5, 7, 0, 1, "R9", 0, 1'b0);

        chk("R10", "read/write overlap cycles", overlap, 0);
        chk("R4", "scoreboard drained", sb_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule